// File: doc/BRIEF.md
# Transition-Limited Data Bus Inversion Codec

This block sits on one channel of a bidirectional DRAM data bus. On the write path it re-codes every byte lane so that each lane travels on nine wires: eight data wires and one inversion flag. It picks the polarity of each beat so that, between one driven transfer and the next, no more than four of those nine wires change level. The decision depends on transitions against the wire levels that were driven last, not on how many ones the byte holds. The last driven levels are kept as state through idle cycles and from one command to the next. Two transfers make one access, which is 32 bytes on a 16-lane (128-bit) channel. The history does not care about that framing and is never cleared between accesses.

On the read path the same block holds the matching decoder. Each received lane is un-inverted whenever its flag wire is high, and the result is registered. Every lane is handled by its own encoder and decoder instance, with no coupling between lanes.

Each encoder lane is a two-state machine that tracks the level of its flag wire. In state POL_PLAIN the flag is low and in POL_INVERT it is high. On every cycle the lane takes one of three transitions. TR_HOLD is taken when no beat is presented: the state and the wires stay as they are. TR_KEEP is taken when the byte, driven with the current flag level, would toggle at most four data wires: the state is kept. TR_FLIP is taken otherwise: the state changes to the opposite polarity and the byte is driven with that polarity.

Top module: `ac_dbi_codec`

## Requirements
- R1: While reset is asserted and directly after it, every transmit data wire and flag wire is 0, every decoded byte is 0 and the decoded-valid output is 0.
- R2: For each lane, the number of its nine wires (eight data plus flag) that differ between two consecutive observed transmit cycles is at most 4.
- R3: One cycle after a transmit beat, each lane's data wires XORed with eight copies of its flag equal the raw byte of that beat (flag high means inverted).
- R4: The flag policy works as follows. The byte XORed with the current flag is compared with the current data wires. If at most 4 bits differ, the flag keeps its level. Otherwise the flag toggles and the byte is driven with the new polarity.
- R5: In a cycle with no transmit beat, the transmit data and flag wires keep their values, whatever is on the raw data input.
- R6: The history is not cleared by idle cycles or between accesses. The first beat after a gap is compared with the last driven levels.
- R7: A lane's wires depend only on that lane's own byte. A lane whose raw byte repeats keeps its wires while other lanes change.
- R8: One cycle after a receive beat, each decoded byte equals the received data wires XORed with eight copies of the received flag, and decoded-valid is 1.
- R9: In a cycle with no receive beat, decoded-valid is 0 one cycle later and the decoded bytes hold.
- R10: A byte that toggles exactly 4 data wires keeps the flag. One that toggles 5 flips it, for a total of 4 toggles. From the reset state, raw lane values 0x0F, 0x1F, 0xFF and 0x00 give wires 0x0F/0, 0xE0/1, 0x00/1 and 0x00/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A write beat is presented this cycle |
| tx_data | input | LANES*LANE_W | Raw write bytes; lane n is bits n*LANE_W upward |
| tx_dq | output | LANES*LANE_W | Encoded data wires driven to the bus |
| tx_dbi | output | LANES | Inversion flag wire per lane |
| rx_valid | input | 1 | A read beat is present on the receive wires |
| rx_dq | input | LANES*LANE_W | Received data wires |
| rx_dbi | input | LANES | Received inversion flag per lane |
| rx_data_valid | output | 1 | Decoded bytes updated by a beat in the previous cycle |
| rx_data | output | LANES*LANE_W | Decoded read bytes |

## Verification
Both paths have one register stage. The encoded wires for a write beat appear one rising edge after that beat is sampled, and the decoded read bytes and their valid appear one rising edge after the receive beat. The bench drives inputs on falling edges. At each rising edge its model consumes the same inputs the design samples, and it compares on the next falling edge, so every comparison lands exactly one cycle after the stimulus. The nine-wire toggle count is measured on the ports between consecutive falling-edge samples. This means holds during idle cycles and changes after a gap are counted the same way as back-to-back beats.

// File: rtl/ac_dbi_pkg.sv
package ac_dbi_pkg;

    // Level of a lane's inversion flag wire; the encoder FSM state.
    typedef enum logic {
        POL_PLAIN  = 1'b0,
        POL_INVERT = 1'b1
    } lane_pol_e;

    // Per-cycle transition taken by an encoder lane.
    typedef enum logic [1:0] {
        TR_HOLD = 2'd0,
        TR_KEEP = 2'd1,
        TR_FLIP = 2'd2
    } lane_step_e;

endpackage

// File: rtl/ac_dbi_tx_lane.sv
module ac_dbi_tx_lane
    import ac_dbi_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int MAX_FLIPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [LANE_W-1:0] raw_byte,
    output logic [LANE_W-1:0] wire_dq,
    output logic              wire_flag
);

    localparam int CNT_W = $clog2(LANE_W + 1);

    lane_pol_e         pol_q;
    lane_pol_e         pol_d;
    lane_step_e        step;
    logic [LANE_W-1:0] dq_q;
    logic [LANE_W-1:0] keep_bits;
    logic [CNT_W-1:0]  keep_dist;

    // Byte as it would be driven if the flag kept its level.
    assign keep_bits = raw_byte ^ {LANE_W{pol_q == POL_INVERT}};
    assign keep_dist = CNT_W'($countones(keep_bits ^ dq_q));

    always_comb begin
        if (!beat_valid) begin
            step = TR_HOLD;
        end else if (keep_dist > CNT_W'(MAX_FLIPS)) begin
            step = TR_FLIP;
        end else begin
            step = TR_KEEP;
        end
    end

    always_comb begin
        pol_d = pol_q;
        unique case (pol_q)
            POL_PLAIN:  pol_d = (step == TR_FLIP) ? POL_INVERT : POL_PLAIN;
            POL_INVERT: pol_d = (step == TR_FLIP) ? POL_PLAIN  : POL_INVERT;
            default:    pol_d = POL_PLAIN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= POL_PLAIN;
        end else begin
            pol_q <= pol_d;
        end
    end

    // Output register: last driven data wire levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else begin
            unique case (step)
                TR_HOLD: dq_q <= dq_q;
                TR_KEEP: dq_q <= keep_bits;
                TR_FLIP: dq_q <= ~keep_bits;
                default: dq_q <= dq_q;
            endcase
        end
    end

    assign wire_dq   = dq_q;
    assign wire_flag = (pol_q == POL_INVERT);

    AST_TOGGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> ($countones({wire_flag, wire_dq} ^ $past({wire_flag, wire_dq})) <= MAX_FLIPS)); // R2

    AST_RECOVERABLE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> ((wire_dq ^ {LANE_W{wire_flag}}) == $past(raw_byte))); // R3

    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && ($countones(raw_byte ^ {LANE_W{wire_flag}} ^ wire_dq) <= MAX_FLIPS))
        |=> $stable(wire_flag)); // R4

    AST_FLAG_FLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && ($countones(raw_byte ^ {LANE_W{wire_flag}} ^ wire_dq) > MAX_FLIPS))
        |=> (wire_flag != $past(wire_flag))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> ($stable(wire_dq) && $stable(wire_flag))); // R5

endmodule

// File: rtl/ac_dbi_rx_lane.sv
module ac_dbi_rx_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [LANE_W-1:0] wire_dq,
    input  logic              wire_flag,
    output logic [LANE_W-1:0] data_out
);

    logic [LANE_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (beat_valid) begin
            data_q <= wire_flag ? ~wire_dq : wire_dq;
        end
    end

    assign data_out = data_q;

    AST_RX_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> ((data_out ^ $past(wire_dq)) == {LANE_W{$past(wire_flag)}})); // R8

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> $stable(data_out)); // R9

endmodule

// File: rtl/ac_dbi_codec.sv
module ac_dbi_codec #(
    parameter int LANES  = 16,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_valid,
    input  logic [LANES*LANE_W-1:0] tx_data,
    output logic [LANES*LANE_W-1:0] tx_dq,
    output logic [LANES-1:0]        tx_dbi,
    input  logic                    rx_valid,
    input  logic [LANES*LANE_W-1:0] rx_dq,
    input  logic [LANES-1:0]        rx_dbi,
    output logic                    rx_data_valid,
    output logic [LANES*LANE_W-1:0] rx_data
);

    // Toggle budget of a lane of LANE_W data wires plus one flag.
    localparam int MAX_FLIPS = (LANE_W + 1) / 2;

    logic rx_vld_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ac_dbi_tx_lane #(
            .LANE_W    (LANE_W),
            .MAX_FLIPS (MAX_FLIPS)
        ) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .beat_valid (tx_valid),
            .raw_byte   (tx_data[g*LANE_W +: LANE_W]),
            .wire_dq    (tx_dq[g*LANE_W +: LANE_W]),
            .wire_flag  (tx_dbi[g])
        );

        ac_dbi_rx_lane #(
            .LANE_W (LANE_W)
        ) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .beat_valid (rx_valid),
            .wire_dq    (rx_dq[g*LANE_W +: LANE_W]),
            .wire_flag  (rx_dbi[g]),
            .data_out   (rx_data[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_vld_q <= 1'b0;
        end else begin
            rx_vld_q <= rx_valid;
        end
    end

    assign rx_data_valid = rx_vld_q;

    AST_RX_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_data_valid); // R8

    AST_RX_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !rx_data_valid); // R9

endmodule

// File: tb/sim_ac_dbi_codec.sv
`timescale 1ns/1ps
module sim_ac_dbi_codec;

    localparam int NL = 4;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            tx_valid = 1'b0;
    logic [NL*W-1:0] tx_data  = '0;
    logic [NL*W-1:0] tx_dq;
    logic [NL-1:0]   tx_dbi;
    logic            rx_valid = 1'b0;
    logic [NL*W-1:0] rx_dq    = '0;
    logic [NL-1:0]   rx_dbi   = '0;
    logic            rx_data_valid;
    logic [NL*W-1:0] rx_data;

    ac_dbi_codec #(.LANES(NL), .LANE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_dq(tx_dq), .tx_dbi(tx_dbi),
        .rx_valid(rx_valid), .rx_dq(rx_dq), .rx_dbi(rx_dbi),
        .rx_data_valid(rx_data_valid), .rx_data(rx_data)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural reference state.
    logic [W-1:0] m_dq   [NL];
    logic         m_flag [NL];
    logic [W-1:0] m_rx   [NL];
    logic         m_rxv;
    logic [W-1:0] obs_dq   [NL];
    logic         obs_flag [NL];
    logic [W-1:0] obs_rx   [NL];

    task automatic check(string tag, bit ok, string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic step(string tag);
        logic         beat;
        logic         rbeat;
        logic [W-1:0] raw [NL];
        @(posedge clk);
        beat  = tx_valid;
        rbeat = rx_valid;
        for (int l = 0; l < NL; l++) begin
            logic [W-1:0] keep;
            raw[l] = tx_data[l*W +: W];
            if (beat) begin
                keep = raw[l] ^ {W{m_flag[l]}};
                if ($countones(keep ^ m_dq[l]) > 4) begin
                    m_flag[l] = ~m_flag[l];
                    m_dq[l]   = ~keep;
                end else begin
                    m_dq[l] = keep;
                end
            end
            if (rbeat) m_rx[l] = rx_dq[l*W +: W] ^ {W{rx_dbi[l]}};
        end
        m_rxv = rbeat;
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            logic [W-1:0] a_dq;
            logic         a_fl;
            int           tg;
            a_dq = tx_dq[l*W +: W];
            a_fl = tx_dbi[l];
            check(tag, a_dq == m_dq[l] && a_fl == m_flag[l],
                $sformatf("lane %0d wires: actual %h/%b expected %h/%b", l, a_dq, a_fl, m_dq[l], m_flag[l]));
            tg = $countones({a_fl, a_dq} ^ {obs_flag[l], obs_dq[l]});
            check("R2", tg <= 4, $sformatf("lane %0d toggles: actual %0d expected <=4", l, tg));
            if (beat)
                check("R3", (a_dq ^ {W{a_fl}}) == raw[l],
                    $sformatf("lane %0d recovered: actual %h expected %h", l, a_dq ^ {W{a_fl}}, raw[l]));
            else
                check("R5", a_dq == obs_dq[l] && a_fl == obs_flag[l],
                    $sformatf("lane %0d idle: actual %h/%b expected %h/%b", l, a_dq, a_fl, obs_dq[l], obs_flag[l]));
            if (rbeat)
                check("R8", rx_data[l*W +: W] == m_rx[l],
                    $sformatf("lane %0d decode: actual %h expected %h", l, rx_data[l*W +: W], m_rx[l]));
            else
                check("R9", rx_data[l*W +: W] == obs_rx[l],
                    $sformatf("lane %0d rx hold: actual %h expected %h", l, rx_data[l*W +: W], obs_rx[l]));
            obs_dq[l]   = a_dq;
            obs_flag[l] = a_fl;
            obs_rx[l]   = rx_data[l*W +: W];
        end
        check(rbeat ? "R8" : "R9", rx_data_valid == m_rxv,
            $sformatf("rx valid: actual %b expected %b", rx_data_valid, m_rxv));
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            m_dq[l] = '0; m_flag[l] = 1'b0; m_rx[l] = '0;
            obs_dq[l] = '0; obs_flag[l] = 1'b0; obs_rx[l] = '0;
        end
        m_rxv = 1'b0;

        // R1: reset state, during and right after reset
        repeat (3) @(negedge clk);
        check("R1", tx_dq == '0 && tx_dbi == '0 && rx_data == '0 && rx_data_valid == 1'b0,
            $sformatf("reset: actual %h/%b/%h/%b expected all zero", tx_dq, tx_dbi, rx_data, rx_data_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", tx_dq == '0 && tx_dbi == '0 && rx_data_valid == 1'b0,
            $sformatf("after reset: actual %h/%b/%b expected zero", tx_dq, tx_dbi, rx_data_valid));

        // R10: boundary beat from reset history
        tx_valid = 1'b1;
        tx_data  = {8'h00, 8'hFF, 8'h1F, 8'h0F};
        step("R10");
        check("R10", tx_dq == {8'h00, 8'h00, 8'hE0, 8'h0F} && tx_dbi == 4'b0110,
            $sformatf("boundary: actual %h/%b expected 0000E00F/0110", tx_dq, tx_dbi));

        // R5: idle cycles with changing raw data
        tx_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tx_data = $urandom;
            step("R5");
        end

        // R6: beat after the gap compares against last driven levels
        tx_valid = 1'b1;
        tx_data  = {8'hF0, 8'h0F, 8'hE0, 8'hFF};
        step("R6");

        // R7: only lane 0 changes; lanes 1..3 repeat their raw byte
        tx_data[7:0] = 8'h55;
        begin
            logic [NL*W-1:0] pd;
            logic [NL-1:0]   pf;
            pd = tx_dq;
            pf = tx_dbi;
            step("R7");
            check("R7", tx_dq[NL*W-1:W] == pd[NL*W-1:W] && tx_dbi[NL-1:1] == pf[NL-1:1],
                $sformatf("other lanes: actual %h/%b expected %h/%b",
                          tx_dq[NL*W-1:W], tx_dbi[NL-1:1], pd[NL*W-1:W], pf[NL-1:1]));
        end

        // R4 / R8 / R9: random traffic, loopback and random receive
        for (int i = 0; i < 600; i++) begin
            tx_valid = ($urandom % 4) != 0;
            tx_data  = $urandom;
            rx_valid = ($urandom % 3) != 0;
            if (i % 2 == 0) begin
                rx_dq  = tx_dq;
                rx_dbi = tx_dbi;
            end else begin
                rx_dq  = $urandom;
                rx_dbi = NL'($urandom);
            end
            step("R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule